// File: doc/BRIEF.md
# Serial Divider Configuration Loader

This block holds the divider settings of an integer-N frequency synthesizer and lets them be set from a three-wire serial port or from hard-wired parallel pins. Serial bits arrive on a slow serial clock and are captured, most significant bit first, into one of two shift registers. The target depends on an enhancement write-enable: a 21-bit primary word (main counter, reference counter, swallow counter and two prescaler controls) or an 8-bit enhancement word. All serial inputs are asynchronous to the system clock. They are brought into the system clock domain by a synchronizer, and their rising edges are found there.

The primary word is double-buffered. Shifting changes only the staging register, and the divider outputs keep their value until a rising edge on either of two transfer strobes copies the staged word into the active register. One strobe is the load strobe, which also gates shifting. The other is a hop strobe, used to switch between pre-staged settings. A mode input routes the parallel pins straight to the outputs in place of the active register. A separate mode input forces the enhancement outputs to zero unless it is low.

Top module: `serial_divider_loader`

## Requirements
- R1: On each rising edge of `ser_clk` that counts as a shift, the primary staging register moves up by one bit and takes `ser_data` into bit 0. The first bit sent therefore ends in bit 20 after 21 shifts (most significant first).
- R2: The 21-bit word is laid out as bits [20:12] main counter M, [11:6] reference counter R, [5:2] swallow counter A, [1] prescaler bypass, [0] 5/6 modulus select.
- R3: With `enh_we` high, serial bits go into the 8-bit enhancement register (most significant first) and the primary staging register is left unchanged.
- R4: While `ld_strobe` is high, serial clock edges shift neither register.
- R5: A rising edge of `ld_strobe` copies the staging register into the active register.
- R6: A rising edge of `hop_strobe` also copies the staging register into the active register. Between transfers, serial shifting leaves the outputs unchanged.
- R7: With `direct_sel` high, the counter and prescaler outputs follow the parallel `dir_*` pins. With it low, they follow the active register.
- R8: `enh_bits` carries the enhancement register only while `enh_mode_n` is low. Otherwise it reads zero.
- R9: When more than 21 bits are shifted before a transfer, only the last 21 bits received are kept.
- R10: After reset, the active register and the enhancement register are zero.
- R11: A strobe held high causes a single transfer. Later shifts reach the outputs only on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, most significant bit first |
| ld_strobe | input | 1 | Load strobe: low allows shifting, rising edge transfers |
| hop_strobe | input | 1 | Hop strobe: rising edge transfers |
| enh_we | input | 1 | High routes serial bits to the enhancement register |
| direct_sel | input | 1 | High selects the parallel pins |
| enh_mode_n | input | 1 | Low enables the enhancement outputs |
| dir_m | input | 9 | Parallel main counter value |
| dir_a | input | 4 | Parallel swallow counter value |
| dir_r | input | 6 | Parallel reference counter value |
| dir_bypass | input | 1 | Parallel prescaler bypass |
| dir_sel56 | input | 1 | Parallel 5/6 modulus select |
| m_val | output | 9 | Active main counter value |
| a_val | output | 4 | Active swallow counter value |
| r_val | output | 6 | Active reference counter value |
| pre_bypass | output | 1 | Active prescaler bypass |
| pre_sel56 | output | 1 | Active 5/6 modulus select |
| enh_bits | output | 8 | Enhancement bits, gated by mode |

## Verification
On every cycle, the assertions check the single-bit shift step of the staging register, that it stays frozen under a high load strobe or during enhancement writes, the exact copy on a transfer, that the active register holds between transfers, and the output gating of the enhancement and direct modes. Only the bench scenarios can show the end-to-end results at the ports. These include the field layout of a serially sent word, the keeping of only the last 21 bits after an overlong burst, the hop path restaging an unchanged word, and a held strobe that does not pass on later shifts.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int M_W   = 9;
  localparam int R_W   = 6;
  localparam int A_W   = 4;
  localparam int CTL_W = 2;
  localparam int PRI_W = M_W + R_W + A_W + CTL_W;
  localparam int ENH_W = 8;
  localparam int NSYNC_IN = 5;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [R_W-1:0] r;
    logic [A_W-1:0] a;
    logic           bypass;
    logic           sel56;
  } cfg_t;
endpackage

// File: rtl/sdl_sync_edge.sv
module sdl_sync_edge #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;
  logic [W-1:0]             prev_q;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q  <= stg_d;
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl  = stg_q[STAGES-1];
  assign rise = stg_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sdl_shifter.sv
module sdl_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             din,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q;
    if (en) q_d = {q[WIDTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/sdl_active_reg.sv
module sdl_active_reg
  import sdl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer,
  input  logic [PRI_W-1:0] staged,
  output cfg_t             act
);
  cfg_t act_d;

  always_comb begin
    act_d = act;
    if (xfer) act_d = cfg_t'(staged);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act <= '0;
    else        act <= act_d;
  end
endmodule

// File: rtl/serial_divider_loader.sv
module serial_divider_loader
  import sdl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ld_strobe,
  input  logic           hop_strobe,
  input  logic           enh_we,
  input  logic           direct_sel,
  input  logic           enh_mode_n,
  input  logic [M_W-1:0] dir_m,
  input  logic [A_W-1:0] dir_a,
  input  logic [R_W-1:0] dir_r,
  input  logic           dir_bypass,
  input  logic           dir_sel56,
  output logic [M_W-1:0] m_val,
  output logic [A_W-1:0] a_val,
  output logic [R_W-1:0] r_val,
  output logic           pre_bypass,
  output logic           pre_sel56,
  output logic [ENH_W-1:0] enh_bits
);
  localparam int I_SCK = 0;
  localparam int I_SDA = 1;
  localparam int I_LD  = 2;
  localparam int I_HOP = 3;
  localparam int I_ENW = 4;

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [NSYNC_IN-1:0] raw_in, in_lvl, in_rise;
  assign raw_in = {enh_we, hop_strobe, ld_strobe, ser_data, ser_clk};

  sdl_sync_edge #(.W(NSYNC_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(raw_in), .lvl(in_lvl), .rise(in_rise)
  );

  logic sh_pri_en, sh_enh_en, xfer, ser_bit;
  assign ser_bit   = in_lvl[I_SDA];
  assign sh_pri_en = in_rise[I_SCK] & ~in_lvl[I_LD] & ~in_lvl[I_ENW];
  assign sh_enh_en = in_rise[I_SCK] & ~in_lvl[I_LD] &  in_lvl[I_ENW];
  assign xfer      = in_rise[I_LD] | in_rise[I_HOP];

  logic [PRI_W-1:0] pri_q;
  logic [ENH_W-1:0] enh_q;

  sdl_shifter #(.WIDTH(PRI_W)) u_pri (
    .clk(clk), .rst_n(rst_int_n), .en(sh_pri_en), .din(ser_bit), .q(pri_q)
  );

  sdl_shifter #(.WIDTH(ENH_W)) u_enh (
    .clk(clk), .rst_n(rst_int_n), .en(sh_enh_en), .din(ser_bit), .q(enh_q)
  );

  cfg_t act;
  sdl_active_reg u_act (
    .clk(clk), .rst_n(rst_int_n), .xfer(xfer), .staged(pri_q), .act(act)
  );

  always_comb begin
    if (direct_sel) begin
      m_val      = dir_m;
      a_val      = dir_a;
      r_val      = dir_r;
      pre_bypass = dir_bypass;
      pre_sel56  = dir_sel56;
    end else begin
      m_val      = act.m;
      a_val      = act.a;
      r_val      = act.r;
      pre_bypass = act.bypass;
      pre_sel56  = act.sel56;
    end
    enh_bits = enh_mode_n ? '0 : enh_q;
  end
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker
  import sdl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             xfer,
  input logic             ld_lvl,
  input logic             sh_pri_en,
  input logic             sh_enh_en,
  input logic             ser_bit,
  input logic [PRI_W-1:0] pri_q,
  input logic [PRI_W-1:0] act,
  input logic             direct_sel,
  input logic [M_W-1:0]   dir_m,
  input logic [M_W-1:0]   m_val,
  input logic             enh_mode_n,
  input logic [ENH_W-1:0] enh_bits
);
  p_shift_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sh_pri_en |=> (pri_q == {$past(pri_q[PRI_W-2:0]), $past(ser_bit)}));

  p_enh_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_enh_en |=> $stable(pri_q));

  p_ld_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lvl |=> $stable(pri_q));

  p_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (act == $past(pri_q)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(act));

  p_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    direct_sel |-> (m_val == dir_m));

  p_enh_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enh_mode_n |-> (enh_bits == '0));
endmodule

bind serial_divider_loader sdl_checker u_chk (
  .clk(clk), .rst_n(rst_int_n), .xfer(xfer), .ld_lvl(in_lvl[2]),
  .sh_pri_en(sh_pri_en), .sh_enh_en(sh_enh_en), .ser_bit(ser_bit),
  .pri_q(pri_q), .act(act), .direct_sel(direct_sel), .dir_m(dir_m),
  .m_val(m_val), .enh_mode_n(enh_mode_n), .enh_bits(enh_bits)
);

// File: tb/serial_divider_loader_test.sv
module serial_divider_loader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 0, ser_data = 0, ld_strobe = 0, hop_strobe = 0, enh_we = 0;
  logic direct_sel = 0, enh_mode_n = 0;
  logic [8:0] dir_m = '0;
  logic [3:0] dir_a = '0;
  logic [5:0] dir_r = '0;
  logic dir_bypass = 0, dir_sel56 = 0;
  logic [8:0] m_val;
  logic [3:0] a_val;
  logic [5:0] r_val;
  logic pre_bypass, pre_sel56;
  logic [7:0] enh_bits;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_divider_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ld_strobe(ld_strobe), .hop_strobe(hop_strobe), .enh_we(enh_we),
    .direct_sel(direct_sel), .enh_mode_n(enh_mode_n), .dir_m(dir_m),
    .dir_a(dir_a), .dir_r(dir_r), .dir_bypass(dir_bypass), .dir_sel56(dir_sel56),
    .m_val(m_val), .a_val(a_val), .r_val(r_val), .pre_bypass(pre_bypass),
    .pre_sel56(pre_sel56), .enh_bits(enh_bits)
  );

  typedef struct {
    logic [8:0] m;
    logic [5:0] r;
    logic [3:0] a;
    logic       b;
    logic       p;
    logic [7:0] e;
    string      tag;
  } exp_t;

  exp_t sb[$];

  task automatic cmp(string tag, string fld, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t x;
      x = sb.pop_front();
      cmp(x.tag, "m", 32'(m_val), 32'(x.m));
      cmp(x.tag, "r", 32'(r_val), 32'(x.r));
      cmp(x.tag, "a", 32'(a_val), 32'(x.a));
      cmp(x.tag, "bypass", 32'(pre_bypass), 32'(x.b));
      cmp(x.tag, "sel56", 32'(pre_sel56), 32'(x.p));
      cmp(x.tag, "enh", 32'(enh_bits), 32'(x.e));
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_word(logic [20:0] w, logic [7:0] e, string tag);
    exp_t x;
    tick(8);
    x.m = w[20:12]; x.r = w[11:6]; x.a = w[5:2]; x.b = w[1]; x.p = w[0];
    x.e = e; x.tag = tag;
    sb.push_back(x);
    tick(2);
  endtask

  task automatic ser_bit(logic b);
    ser_data = b;
    tick(3);
    ser_clk = 1'b1;
    tick(6);
    ser_clk = 1'b0;
    tick(3);
  endtask

  task automatic shift_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) ser_bit(v[i]);
  endtask

  task automatic pulse_ld();
    ld_strobe = 1'b1; tick(6); ld_strobe = 1'b0; tick(6);
  endtask

  task automatic pulse_hop();
    hop_strobe = 1'b1; tick(6); hop_strobe = 1'b0; tick(6);
  endtask

  localparam logic [20:0] W1 = {9'h1A5, 6'h2B, 4'h9, 1'b1, 1'b0};
  localparam logic [20:0] W2 = {9'h0F3, 6'h15, 4'h6, 1'b0, 1'b1};
  localparam logic [20:0] W3 = {9'h155, 6'h3C, 4'h3, 1'b1, 1'b1};
  localparam logic [20:0] W4 = {9'h0AA, 6'h01, 4'hC, 1'b0, 1'b0};
  localparam logic [20:0] W5 = {9'h1FF, 6'h00, 4'hF, 1'b0, 1'b1};

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);
    expect_word('0, 8'h00, "R10 reset");

    shift_bits(32'(W1), 21);
    expect_word('0, 8'h00, "R6 shift without transfer");
    pulse_ld();
    expect_word(W1, 8'h00, "R1 R2 R5 load transfer");

    shift_bits({7'h0, 4'hA, W2}, 25);
    pulse_ld();
    expect_word(W2, 8'h00, "R9 last bits kept");

    enh_we = 1'b1; tick(4);
    shift_bits({22'h0, 2'b11, 8'h5C}, 10);
    enh_we = 1'b0; tick(4);
    expect_word(W2, 8'h5C, "R3 enhancement write");
    pulse_hop();
    expect_word(W2, 8'h5C, "R3 staging untouched");

    shift_bits(32'(W3), 21);
    pulse_hop();
    expect_word(W3, 8'h5C, "R6 hop transfer");

    ld_strobe = 1'b1; tick(4);
    shift_bits(32'(W4), 21);
    ld_strobe = 1'b0; tick(4);
    expect_word(W3, 8'h5C, "R4 no transfer on falling edge");
    pulse_hop();
    expect_word(W3, 8'h5C, "R4 shift blocked by load");

    hop_strobe = 1'b1; tick(6);
    shift_bits(32'(W5), 21);
    expect_word(W3, 8'h5C, "R11 held strobe");
    hop_strobe = 1'b0; tick(6);
    hop_strobe = 1'b1; tick(6);
    hop_strobe = 1'b0; tick(4);
    expect_word(W5, 8'h5C, "R11 next edge");

    enh_mode_n = 1'b1;
    expect_word(W5, 8'h00, "R8 enhancement gated");
    enh_mode_n = 1'b0;
    expect_word(W5, 8'h5C, "R8 enhancement enabled");

    dir_m = 9'h0C3; dir_r = 6'h27; dir_a = 4'h5; dir_bypass = 1'b1; dir_sel56 = 1'b1;
    direct_sel = 1'b1;
    expect_word({9'h0C3, 6'h27, 4'h5, 1'b1, 1'b1}, 8'h5C, "R7 direct pins");
    direct_sel = 1'b0;
    expect_word(W5, 8'h5C, "R7 serial restored");

    tick(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule